// File: doc/BRIEF.md
# LIN Break Generator and Detector

This block sits beside a UART and adds the break handling that a LIN bus needs. On the transmit side, a master raises a one-cycle request, and the block takes over the transmit line. It holds the line low for 13 bit times and then high for a short delimiter. After that it gives the line back and clears the pending request itself.

On the receive side, the block samples the receive line once per bit time and counts how many samples in a row are low. When the run reaches the chosen threshold of 10 or 11 bit times, it reports a break from a slave node.

Bit timing comes from the UART's baud tick, which is one clock-wide pulse per bit period. Detection runs alongside normal reception. A frame of all zeros, which the UART would otherwise report as a framing error, is reported as a break instead. While the block is not enabled for LIN operation, it does nothing and passes framing errors through unchanged.

Top module: `lin_break_unit`

## Requirements
- R1: While `lin_en` is 0, the block behaves as follows: `tx_hold` stays 0, `brk_pending` stays 0, `send_brk` is ignored, `brk_det` stays 0, and `frm_err_out` equals `frm_err_in`.
- R2: After a `send_brk` pulse with `lin_en` set, the block starts the break at the next baud tick. It then holds `tx_hold`=1 and `tx_level`=0 for exactly 13 bit periods, which is 13 baud ticks.
- R3: After the low period, the block holds `tx_hold`=1 and `tx_level`=1 for DELIM_BITS bit periods (default 1). Then `tx_hold` returns to 0.
- R4: A `send_brk` pulse sets `brk_pending`. The hardware clears `brk_pending` in the same cycle in which `tx_hold` falls.
- R5: `rx_line` is sampled on each baud tick. With `det_long`=0, a run of 10 consecutive low samples raises a break, and a run of 9 does not. With `det_long`=1, the thresholds are 11 and 10.
- R6: `brk_det` is a single-cycle pulse. It is asserted in the clock cycle that follows the baud tick that completed the low run.
- R7: A high sample on `rx_line` restarts the low-run count. Two runs of 6 low samples with one high sample between them raise no break.
- R8: After a break, the detector does not re-arm until it takes a high sample. A low run of 25 samples gives exactly one `brk_det` pulse. A new low run after a high sample can give another pulse.
- R9: While enabled, `frm_err_out` is forced to 0 in two cases: when the current low run has reached 9 samples or more, and when the detector is waiting to re-arm after a break. Otherwise `frm_err_out` follows `frm_err_in` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lin_en | input | 1 | Enable for LIN break handling |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| send_brk | input | 1 | One-cycle request to send a break |
| det_long | input | 1 | Detection length: 0 selects 10 bits, 1 selects 11 bits |
| rx_line | input | 1 | Serial receive line |
| frm_err_in | input | 1 | Framing error from the UART receiver |
| tx_hold | output | 1 | Block owns the transmit line |
| tx_level | output | 1 | Level to drive on the transmit line while `tx_hold` is 1 |
| brk_pending | output | 1 | Break request accepted and not yet finished |
| brk_det | output | 1 | Break-detected pulse |
| frm_err_out | output | 1 | Framing error after break masking |

## Verification
The transmit outputs come straight from a state register. The break therefore begins one clock after the first baud tick that follows the request, and each phase lasts a whole number of baud-tick intervals. The bench measures each phase by counting clocks at falling edges, and it expects 13 and DELIM_BITS multiples of the tick spacing.

`brk_det` is registered. It appears in the cycle after the completing tick. A monitor on the falling edge counts pulses and their widths over the whole scenario, so the count is compared once the line has been released.

The framing-error mask is combinational. It is checked in the same falling-edge window in which `frm_err_in` is applied, after the bench has counted the required number of low ticks.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_LOW   = 2'd1,
      TX_DELIM = 2'd2
   } tx_state_e;

   // Width needed to hold values 0..n.
   function automatic int cnt_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/lin_brk_tx.sv
module lin_brk_tx
   import lin_brk_pkg::*;
#(
   parameter int BRK_BITS   = 13,
   parameter int DELIM_BITS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic tick,
   input  logic request,
   output logic hold,
   output logic level,
   output logic pending
);
   localparam int MAXC = (BRK_BITS > DELIM_BITS) ? BRK_BITS : DELIM_BITS;
   localparam int CW   = cnt_width(MAXC);
   localparam logic [CW-1:0] LOW_LAST   = CW'(BRK_BITS - 1);
   localparam logic [CW-1:0] DELIM_LAST = CW'(DELIM_BITS - 1);

   tx_state_e      state_q;
   logic [CW-1:0]  cnt_q;
   logic           pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         cnt_q   <= '0;
         pend_q  <= 1'b0;
      end else if (!enable) begin
         state_q <= TX_IDLE;
         cnt_q   <= '0;
         pend_q  <= 1'b0;
      end else begin
         if (request && !pend_q)
            pend_q <= 1'b1;
         if (tick) begin
            unique case (state_q)
               TX_IDLE: begin
                  if (pend_q) begin
                     state_q <= TX_LOW;
                     cnt_q   <= '0;
                  end
               end
               TX_LOW: begin
                  if (cnt_q == LOW_LAST) begin
                     state_q <= TX_DELIM;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               TX_DELIM: begin
                  if (cnt_q == DELIM_LAST) begin
                     state_q <= TX_IDLE;
                     cnt_q   <= '0;
                     pend_q  <= 1'b0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: state_q <= TX_IDLE;
            endcase
         end
      end
   end

   assign hold    = (state_q != TX_IDLE);
   assign level   = (state_q == TX_DELIM);
   assign pending = pend_q;

   AST_HOLD_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> pending);                                      // R4
   AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold) |-> !pending);                              // R4
   AST_DELIM_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hold) && !$past(level) && level) |-> hold);       // R3
   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!hold && !pending));                       // R1

endmodule

// File: rtl/lin_brk_rx.sv
module lin_brk_rx
   import lin_brk_pkg::*;
#(
   parameter int SHORT_THR    = 10,
   parameter int LONG_THR     = 11,
   parameter int FE_MASK_FROM = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic tick,
   input  logic rx,
   input  logic sel_long,
   output logic detect,
   output logic fe_mask
);
   localparam int TOP = (LONG_THR > SHORT_THR) ? LONG_THR : SHORT_THR;
   localparam int CW  = cnt_width(TOP);
   localparam logic [CW-1:0] SAT    = {CW{1'b1}};
   localparam logic [CW-1:0] THR_S  = CW'(SHORT_THR);
   localparam logic [CW-1:0] THR_L  = CW'(LONG_THR);
   localparam logic [CW-1:0] MASK_F = CW'(FE_MASK_FROM);

   logic [CW-1:0] run_q;
   logic [CW-1:0] run_inc;
   logic [CW-1:0] thr;
   logic          armed_q;
   logic          det_q;

   assign thr     = sel_long ? THR_L : THR_S;
   assign run_inc = (run_q == SAT) ? run_q : run_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= '0;
         armed_q <= 1'b1;
         det_q   <= 1'b0;
      end else if (!enable) begin
         run_q   <= '0;
         armed_q <= 1'b1;
         det_q   <= 1'b0;
      end else begin
         det_q <= 1'b0;
         if (tick) begin
            if (rx) begin
               run_q   <= '0;
               armed_q <= 1'b1;
            end else begin
               run_q <= run_inc;
               if (armed_q && (run_inc == thr)) begin
                  det_q   <= 1'b1;
                  armed_q <= 1'b0;
               end
            end
         end
      end
   end

   assign detect  = det_q;
   assign fe_mask = enable && ((run_q >= MASK_F) || !armed_q);

   AST_DET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      detect |=> !detect);                                    // R6
   AST_DET_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(detect) |-> ($past(tick) && !$past(rx)));         // R5
   AST_NO_DET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !detect);                                   // R1
   AST_DISARM_AFTER_DET: assert property (@(posedge clk) disable iff (!rst_n)
      detect |-> fe_mask);                                    // R8

endmodule

// File: rtl/lin_break_unit.sv
module lin_break_unit
   import lin_brk_pkg::*;
#(
   parameter int BRK_BITS     = 13,
   parameter int DELIM_BITS   = 1,
   parameter int SHORT_THR    = 10,
   parameter int LONG_THR     = 11,
   parameter int FE_MASK_FROM = 9,
   parameter bit FE_SUPPRESS  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lin_en,
   input  logic baud_tick,
   input  logic send_brk,
   input  logic det_long,
   input  logic rx_line,
   input  logic frm_err_in,
   output logic tx_hold,
   output logic tx_level,
   output logic brk_pending,
   output logic brk_det,
   output logic frm_err_out
);
   if (BRK_BITS < 1 || DELIM_BITS < 1) begin : g_bad_tx
      $error("break and delimiter lengths must be at least one bit");
   end
   if (SHORT_THR < 2 || LONG_THR < SHORT_THR) begin : g_bad_rx
      $error("detection thresholds out of order");
   end
   if (FE_MASK_FROM < 1 || FE_MASK_FROM > SHORT_THR) begin : g_bad_mask
      $error("framing mask start must not exceed the short threshold");
   end

   logic fe_mask;

   lin_brk_tx #(
      .BRK_BITS   (BRK_BITS),
      .DELIM_BITS (DELIM_BITS)
   ) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (lin_en),
      .tick    (baud_tick),
      .request (send_brk),
      .hold    (tx_hold),
      .level   (tx_level),
      .pending (brk_pending)
   );

   lin_brk_rx #(
      .SHORT_THR    (SHORT_THR),
      .LONG_THR     (LONG_THR),
      .FE_MASK_FROM (FE_MASK_FROM)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (lin_en),
      .tick     (baud_tick),
      .rx       (rx_line),
      .sel_long (det_long),
      .detect   (brk_det),
      .fe_mask  (fe_mask)
   );

   if (FE_SUPPRESS) begin : g_fe_mask
      assign frm_err_out = frm_err_in && !fe_mask;
   end else begin : g_fe_pass
      assign frm_err_out = frm_err_in;
   end

   AST_FE_ONLY_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      frm_err_out |-> frm_err_in);                            // R9
   AST_FE_PASS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !lin_en |-> (frm_err_out == frm_err_in));               // R1

endmodule

// File: tb/lin_break_unit_tb.sv
module lin_break_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int BIT_CLKS   = 4;
   localparam int DELIM_BITS = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lin_en = 1'b0;
   logic baud_tick = 1'b0;
   logic send_brk = 1'b0;
   logic det_long = 1'b0;
   logic rx_line = 1'b1;
   logic frm_err_in = 1'b0;
   logic tx_hold, tx_level, brk_pending, brk_det, frm_err_out;

   int n_checks = 0;
   int n_fail = 0;
   int det_pulses = 0;
   int det_wide = 0;
   int tick_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lin_break_unit #(.DELIM_BITS(DELIM_BITS)) u_dut (
      .clk(clk), .rst_n(rst_n), .lin_en(lin_en), .baud_tick(baud_tick),
      .send_brk(send_brk), .det_long(det_long), .rx_line(rx_line),
      .frm_err_in(frm_err_in), .tx_hold(tx_hold), .tx_level(tx_level),
      .brk_pending(brk_pending), .brk_det(brk_det), .frm_err_out(frm_err_out)
   );

   always @(posedge clk) begin
      tick_cnt  <= (tick_cnt == BIT_CLKS-1) ? 0 : tick_cnt + 1;
      baud_tick <= (tick_cnt == BIT_CLKS-1);
   end

   logic det_prev = 1'b0;
   always @(negedge clk) begin
      if (brk_det) det_pulses++;
      if (brk_det && det_prev) det_wide++;
      det_prev <= brk_det;
   end

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_tick();
      @(negedge clk);
      while (!baud_tick) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic low_run(input int n);
      rx_line = 1'b0;
      for (int i = 0; i < n; i++) wait_tick();
      rx_line = 1'b1;
      for (int i = 0; i < 3; i++) wait_tick();
   endtask

   task automatic t_reset();
      check("R1 reset tx_hold", tx_hold, 0);
      check("R1 reset pending", brk_pending, 0);
      check("R1 reset brk_det", brk_det, 0);
   endtask

   task automatic t_send();
      int low_c = 0, delim_c = 0, guard = 0;
      bit fell_ok = 1'b1;
      @(negedge clk); send_brk = 1'b1;
      @(negedge clk); send_brk = 1'b0;
      check("R4 pending set", brk_pending, 1);
      while (!tx_hold && guard < 100) begin @(negedge clk); guard++; end
      while (tx_hold && guard < 500) begin
         if (!tx_level) low_c++; else delim_c++;
         @(negedge clk); guard++;
         if (!tx_hold && brk_pending) fell_ok = 1'b0;
      end
      check("R2 low cycles", low_c, 13*BIT_CLKS);
      check("R3 delimiter cycles", delim_c, DELIM_BITS*BIT_CLKS);
      check("R4 pending cleared with release", fell_ok, 1);
      check("R3 line released", tx_hold, 0);
   endtask

   task automatic t_detect(input bit lng, input int n, input int exp, input string req);
      det_long = lng;
      det_pulses = 0;
      low_run(n);
      check(req, det_pulses, exp);
   endtask

   task automatic t_restart();
      det_long = 1'b0;
      det_pulses = 0;
      rx_line = 1'b0;
      for (int i = 0; i < 6; i++) wait_tick();
      rx_line = 1'b1; wait_tick();
      low_run(6);
      check("R7 restart on high sample", det_pulses, 0);
   endtask

   task automatic t_rearm();
      det_long = 1'b0;
      det_pulses = 0; det_wide = 0;
      low_run(25);
      check("R8 single pulse long low", det_pulses, 1);
      check("R6 pulse width one cycle", det_wide, 0);
      det_pulses = 0;
      low_run(10);
      check("R8 rearmed after high", det_pulses, 1);
   endtask

   task automatic t_fe();
      det_long = 1'b0;
      frm_err_in = 1'b1; #1;
      check("R9 pass when line high", frm_err_out, 1);
      rx_line = 1'b0;
      for (int i = 0; i < 9; i++) wait_tick();
      #1; check("R9 masked at 9 low", frm_err_out, 0);
      frm_err_in = 1'b0;
      for (int i = 0; i < 4; i++) wait_tick();
      frm_err_in = 1'b1; #1;
      check("R9 masked while disarmed", frm_err_out, 0);
      frm_err_in = 1'b0;
      rx_line = 1'b1;
      for (int i = 0; i < 3; i++) wait_tick();
      rx_line = 1'b0;
      for (int i = 0; i < 3; i++) wait_tick();
      frm_err_in = 1'b1; #1;
      check("R9 pass at short low", frm_err_out, 1);
      frm_err_in = 1'b0;
      rx_line = 1'b1;
      for (int i = 0; i < 3; i++) wait_tick();
   endtask

   task automatic t_disabled();
      int holds = 0;
      lin_en = 1'b0;
      @(negedge clk); send_brk = 1'b1;
      @(negedge clk); send_brk = 1'b0;
      for (int i = 0; i < 20*BIT_CLKS; i++) begin
         if (tx_hold || brk_pending) holds++;
         @(negedge clk);
      end
      check("R1 request ignored", holds, 0);
      det_pulses = 0;
      low_run(12);
      check("R1 no detect when off", det_pulses, 0);
      rx_line = 1'b0;
      for (int i = 0; i < 10; i++) wait_tick();
      frm_err_in = 1'b1; #1;
      check("R1 framing error passes", frm_err_out, 1);
      frm_err_in = 1'b0; rx_line = 1'b1;
      wait_tick();
      lin_en = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      lin_en = 1'b1;
      wait_tick();
      t_send();
      t_detect(1'b0, 10, 1, "R5 short threshold 10");
      t_detect(1'b0, 9,  0, "R5 short run 9");
      t_detect(1'b1, 10, 0, "R5 long run 10");
      t_detect(1'b1, 11, 1, "R5 long threshold 11");
      t_restart();
      t_rearm();
      t_fe();
      t_disabled();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule